// File: doc/BRIEF.md
# Three-Phase Gate Commutation Controller

This block drives the six gate inputs of a three-phase inverter bridge that runs a brushless motor. The gates form two groups of three: high-side (positive) and low-side (reverse). A 3-bit rotor phase state picks which gates may conduct. That state comes either from three feedback inputs, such as hall sensors or capture events, or from three phase bits that software writes into a control register.

A six-step commutation table turns the phase state into gate enables. The table enables exactly one high-side gate and one low-side gate, and the two always belong to different phases. Each group has its own output mode bit in the control register. An enabled gate in static mode drives a constant active level. An enabled gate in PWM mode passes through a PWM waveform that comes in on a pin. A disabled gate always drives 0.

The feedback inputs are asynchronous, so they pass through a synchronizer before the decode. PWM generation, capture and dead-time insertion are done outside this block.

Top module: `bldc_gate_ctrl`

## Requirements
- R1: While reset is active and after it is released, the control register reads 0x00 and all six gate outputs are 0.
- R2: A write (`cfg_we`=1) loads `cfg_wdata` at the clock edge, and `cfg_rdata` shows the new value from the next cycle on. The register fields are: bit 7 is the reverse-group mode, bit 6 is the positive-group mode, bit 3 is the phase source, and bits 2..0 are the software phase, with bit 0 = U, bit 1 = V and bit 2 = W. Bits 5..4 are not stored and always read 0.
- R3: Bit 3 = 0 takes the phase state from `fb_in`. Bit 3 = 1 takes the phase state from register bits 2..0.
- R4: While bit 3 is 0, writes to bits 2..0 have no effect on the gate outputs.
- R5: The commutation table maps each valid phase value to one positive gate and one reverse gate: 101 gives pos U / rev V, 100 gives pos U / rev W, 110 gives pos V / rev W, 010 gives pos V / rev U, 011 gives pos W / rev U, and 001 gives pos W / rev V. Gate vector bit 0 = U, bit 1 = V, bit 2 = W.
- R6: The phase states 000 and 111 disable all six gates.
- R7: When bit 6 is 0, an enabled positive gate drives 1. When bit 6 is 1, it drives `pwm_pos`. A disabled positive gate drives 0 in either mode.
- R8: When bit 7 is 0, an enabled reverse gate drives 1. When bit 7 is 1, it drives `pwm_neg`. A disabled reverse gate drives 0. This setting is independent of bit 6.
- R9: The gate enables change one clock edge after the selected phase value changes. A change on `fb_in` therefore reaches the gates after SYNC_STAGES+1 edges (3 by default), and a software phase write reaches them after 2 edges. A change of mode bit reaches the gates in the same cycle that it appears on `cfg_rdata`.
- R10: At most one gate per group is high at any time, and the positive and reverse gates of the same phase are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register readback |
| fb_in | input | 3 | Asynchronous phase feedback, bit 0 = U, bit 1 = V, bit 2 = W |
| pwm_pos | input | 1 | PWM waveform for the positive group |
| pwm_neg | input | 1 | PWM waveform for the reverse group |
| gate_pos | output | 3 | Positive-phase gate drives (U, V, W) |
| gate_neg | output | 3 | Reverse-phase gate drives (U, V, W) |

## Verification
The bench builds the block with SYNC_STAGES = 2, which makes the feedback path exactly three edges long. This lets the bench pin down the latency of R9 on the cycle it occurs, for both phase sources. With the default width of three phases, a complete sweep of all eight phase states is possible under both sources, all four mode combinations and both PWM levels. Random configurations then mix register writes with feedback changes, and the bench compares every gate output against its own model of the table.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

    localparam int NPH   = 3;
    localparam int CFG_W = 8;

    localparam int BIT_NEG_MODE = 7;
    localparam int BIT_POS_MODE = 6;
    localparam int BIT_SRC_SW   = 3;

    localparam logic [CFG_W-1:0] CFG_MASK = 8'hCF;

    typedef logic [NPH-1:0] phase_t;

    typedef struct packed {
        phase_t pos;
        phase_t neg;
    } gate_en_t;

    function automatic gate_en_t commutate(input phase_t ph);
        gate_en_t r;
        r = '{pos: 3'b000, neg: 3'b000};
        case (ph)
            3'b101: r = '{pos: 3'b001, neg: 3'b010};
            3'b100: r = '{pos: 3'b001, neg: 3'b100};
            3'b110: r = '{pos: 3'b010, neg: 3'b100};
            3'b010: r = '{pos: 3'b010, neg: 3'b001};
            3'b011: r = '{pos: 3'b100, neg: 3'b001};
            3'b001: r = '{pos: 3'b100, neg: 3'b010};
            default: r = '{pos: 3'b000, neg: 3'b000};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bgc_cfg_reg.sv
module bgc_cfg_reg
    import bgc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output logic             pos_pwm,
    output logic             neg_pwm,
    output logic             src_sw,
    output phase_t           sw_phase
);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.cfg = wdata & CFG_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.cfg;
    assign pos_pwm  = st_q.cfg[BIT_POS_MODE];
    assign neg_pwm  = st_q.cfg[BIT_NEG_MODE];
    assign src_sw   = st_q.cfg[BIT_SRC_SW];
    assign sw_phase = st_q.cfg[NPH-1:0];

endmodule

// File: rtl/bgc_fb_sync.sv
module bgc_fb_sync
    import bgc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t fb_async,
    output phase_t fb_sync
);

    typedef struct packed {
        logic [STAGES-1:0][NPH-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = fb_async;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fb_sync = st_q.chain[STAGES-1];

endmodule

// File: rtl/bgc_commutate.sv
module bgc_commutate
    import bgc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase,
    output phase_t en_pos,
    output phase_t en_neg
);

    typedef struct packed {
        gate_en_t en;
    } comm_state_t;

    comm_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = commutate(phase);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_pos = st_q.en.pos;
    assign en_neg = st_q.en.neg;

endmodule

// File: rtl/bgc_out_mux.sv
module bgc_out_mux
    import bgc_pkg::*;
(
    input  phase_t en,
    input  logic   pwm_mode,
    input  logic   pwm,
    output phase_t gate
);

    for (genvar g = 0; g < NPH; g++) begin : g_pin
        always_comb begin
            if (!en[g]) begin
                gate[g] = 1'b0;
            end else if (pwm_mode) begin
                gate[g] = pwm;
            end else begin
                gate[g] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bldc_gate_ctrl.sv
module bldc_gate_ctrl
    import bgc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic [2:0] fb_in,
    input  logic       pwm_pos,
    input  logic       pwm_neg,
    output logic [2:0] gate_pos,
    output logic [2:0] gate_neg
);

    logic   pos_pwm, neg_pwm, src_sw;
    phase_t sw_phase, fb_sync, phase_sel, en_pos, en_neg;

    bgc_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .pos_pwm  (pos_pwm),
        .neg_pwm  (neg_pwm),
        .src_sw   (src_sw),
        .sw_phase (sw_phase)
    );

    bgc_fb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .fb_async (fb_in),
        .fb_sync  (fb_sync)
    );

    assign phase_sel = src_sw ? sw_phase : fb_sync;

    bgc_commutate u_comm (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase  (phase_sel),
        .en_pos (en_pos),
        .en_neg (en_neg)
    );

    bgc_out_mux u_mux_pos (
        .en       (en_pos),
        .pwm_mode (pos_pwm),
        .pwm      (pwm_pos),
        .gate     (gate_pos)
    );

    bgc_out_mux u_mux_neg (
        .en       (en_neg),
        .pwm_mode (neg_pwm),
        .pwm      (pwm_neg),
        .gate     (gate_neg)
    );

endmodule

// File: rtl/bldc_gate_ctrl_chk.sv
module bldc_gate_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic [2:0] phase_sel,
    input logic       pwm_pos,
    input logic       pwm_neg,
    input logic [2:0] gate_pos,
    input logic [2:0] gate_neg
);

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == ($past(cfg_wdata) & 8'hCF));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[5:4] == 2'b00);

    a_r6_invalid_off: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_sel == 3'b000 || phase_sel == 3'b111) |=> (gate_pos == 3'b000 && gate_neg == 3'b000));

    a_r10_one_per_group: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_pos) && $onehot0(gate_neg));

    a_r10_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_pos & gate_neg) == 3'b000);

    a_r7_pwm_gated_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[6] && gate_pos != 3'b000) |-> pwm_pos);

    a_r8_pwm_gated_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7] && gate_neg != 3'b000) |-> pwm_neg);

endmodule

bind bldc_gate_ctrl bldc_gate_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .phase_sel (phase_sel),
    .pwm_pos   (pwm_pos),
    .pwm_neg   (pwm_neg),
    .gate_pos  (gate_pos),
    .gate_neg  (gate_neg)
);

// File: tb/bldc_gate_ctrl_bench.sv
module bldc_gate_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [2:0] fb_in = '0;
    logic       pwm_pos = 1'b0;
    logic       pwm_neg = 1'b0;
    logic [2:0] gate_pos, gate_neg;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bldc_gate_ctrl #(.SYNC_STAGES(2)) u_bldc_gate_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .fb_in     (fb_in),
        .pwm_pos   (pwm_pos),
        .pwm_neg   (pwm_neg),
        .gate_pos  (gate_pos),
        .gate_neg  (gate_neg)
    );

    // R5 table model: returns {pos, neg}
    function automatic logic [5:0] model_en(input logic [2:0] ph);
        case (ph)
            3'b101: return {3'b001, 3'b010};
            3'b100: return {3'b001, 3'b100};
            3'b110: return {3'b010, 3'b100};
            3'b010: return {3'b010, 3'b001};
            3'b011: return {3'b100, 3'b001};
            3'b001: return {3'b100, 3'b010};
            default: return 6'b0;
        endcase
    endfunction

    // R7/R8 output model
    function automatic logic [5:0] model_gates(input logic [2:0] ph, input logic pm,
                                               input logic nm, input logic pp, input logic pn);
        logic [5:0] e;
        logic [2:0] p, n;
        e = model_en(ph);
        p = e[5:3] & {3{pm ? pp : 1'b1}};
        n = e[2:0] & {3{nm ? pn : 1'b1}};
        return {p, n};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // checks gates for both pwm levels
    task automatic check_all(input string req, input logic [2:0] ph, input logic pm, input logic nm);
        for (int k = 0; k < 4; k++) begin
            pwm_pos = k[0];
            pwm_neg = k[1];
            #0.5;
            check(req, {26'd0, gate_pos, gate_neg}, {26'd0, model_gates(ph, pm, nm, k[0], k[1])});
        end
    endtask

    initial begin
        int unsigned seed;
        logic [7:0] cfg;
        seed = 32'd12345;
        void'($urandom(seed));

        // R1 reset
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", {24'd0, cfg_rdata}, 32'd0);
        check("R1 gates in reset", {26'd0, gate_pos, gate_neg}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", {24'd0, cfg_rdata}, 32'd0);

        // R2 write/readback with reserved bits
        wr(8'hFF);
        check("R2 readback mask", {24'd0, cfg_rdata}, 32'hCF);
        wr(8'h00);
        check("R2 readback zero", {24'd0, cfg_rdata}, 32'h0);

        // R3 R5 R6 R7 R8 full sweep
        for (int src = 0; src < 2; src++) begin
            for (int m = 0; m < 4; m++) begin
                for (int ph = 0; ph < 8; ph++) begin
                    if (src == 0) begin
                        fb_in = ph[2:0];
                        wr({m[1], m[0], 2'b00, 1'b0, 3'b000});
                    end else begin
                        wr({m[1], m[0], 2'b00, 1'b1, ph[2:0]});
                    end
                    settle();
                    if (ph == 0 || ph == 7)
                        check_all("R6 invalid state", ph[2:0], m[0], m[1]);
                    else if (m == 0)
                        check_all("R5 table", ph[2:0], 1'b0, 1'b0);
                    else if (m == 1)
                        check_all("R7 pos pwm mode", ph[2:0], 1'b1, 1'b0);
                    else if (m == 2)
                        check_all("R8 neg pwm mode", ph[2:0], 1'b0, 1'b1);
                    else
                        check_all("R3 source sweep", ph[2:0], 1'b1, 1'b1);
                end
            end
        end

        // R4 software bits ignored under feedback source
        fb_in = 3'b110;
        wr(8'h00);
        settle();
        for (int ph = 0; ph < 8; ph++) begin
            wr({5'b00000, ph[2:0]});
            settle();
            check_all("R4 sw bits ignored", 3'b110, 1'b0, 1'b0);
        end

        // R9 feedback latency: 3 edges
        fb_in = 3'b101;
        wr(8'h00);
        settle();
        @(negedge clk);
        fb_in = 3'b011;
        pwm_pos = 1'b0;
        pwm_neg = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 fb after 2 edges old", {26'd0, gate_pos, gate_neg}, {26'd0, model_gates(3'b101, 0, 0, 0, 0)});
        @(negedge clk);
        check("R9 fb after 3 edges new", {26'd0, gate_pos, gate_neg}, {26'd0, model_gates(3'b011, 0, 0, 0, 0)});

        // R9 software latency: 2 edges; mode immediate
        wr(8'h0A);
        settle();
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = 8'hCC;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R9 sw after 1 edge old", {26'd0, gate_pos, gate_neg}, {26'd0, model_gates(3'b010, 1, 1, 0, 0)});
        @(negedge clk);
        check("R9 sw after 2 edges new", {26'd0, gate_pos, gate_neg}, {26'd0, model_gates(3'b100, 1, 1, 0, 0)});

        // random mix
        for (int it = 0; it < 300; it++) begin
            cfg = 8'($urandom());
            fb_in = 3'($urandom());
            wr(cfg);
            settle();
            check_all(cfg[3] ? "R3 random sw source" : "R3 random fb source",
                      cfg[3] ? cfg[2:0] : fb_in, cfg[6], cfg[7]);
            check("R2 random readback", {24'd0, cfg_rdata}, {24'd0, cfg & 8'hCF});
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule